// File: doc/BRIEF.md
# ATA PIO Sector Transfer Engine

This block drives a parallel ATA/IDE-style task-file register bus to run one single-sector programmed-I/O command at a time. A host hands over a command byte and a sector number. The engine then programs the device registers, waits for the device, and moves one 512-byte sector as 256 sixteen-bit words through the device data register. The engine supports three commands: identify-device, read-sector and write-sector.

On the inbound side (identify and read), each word is written to a local buffer write port. Buffer word k holds sector bytes 2k (low byte) and 2k+1 (high byte). On the outbound side (write), words are fetched from a buffer read port with one cycle of latency. The engine sends them in address order.

The engine checks the final device status for the error and busy bits. Every wait on the device is guarded by a cycle limit, so a silent device cannot hang the host. When the command finishes, the engine reports a done pulse together with an error flag and a timeout flag.

Top module: `ata_pio_engine`

## Requirements
- R1: While reset is high and in the cycle after it, busy, done, dev_wr, dev_rd and buf_we are all 0.
- R2: Read (0x20) and write (0x30) issue exactly three register writes, in this order: sector count (offset 0x09) = 1, sector number (offset 0x0B) = the host sector byte, then command/status (offset 0x1D) = the command code. Identify (0xEC) issues only the command write at 0x1D.
- R3: For identify and read, the engine waits until dev_intrq_n is low. It then reads status at offset 0x1D, and only after that does it read the data register at offset 0.
- R4: Identify and read perform exactly 256 data-register reads. The k-th value read is written to buffer address k.
- R5: For write, the engine repeatedly reads status at 0x1D. It writes no data until a status with bit 3 (DRQ) set and bit 7 (BSY) clear is seen.
- R6: Write performs exactly 256 data-register writes at offset 0. Write k carries the buffer word at address k.
- R7: After the last write word, the engine waits for dev_intrq_n low and reads status once more before finishing. Done is a single-cycle pulse.
- R8: At done, error is 1 exactly when the status read after the interrupt has bit 0 (ERR) or bit 7 (BSY) set; otherwise error is 0.
- R9: If the interrupt wait or the DRQ wait lasts TIMEOUT_CYC cycles, the command ends with done, error = 1 and timed_out = 1, and no data word is moved.
- R10: A command code other than 0xEC, 0x20 or 0x30 ends with done and error = 1, with no device-bus access at all.
- R11: cmd_valid is ignored while busy is high. A second request during a command causes no further register write and does not change the running transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Host command request, taken when busy is low |
| cmd_code | input | 8 | Command byte |
| cmd_sector | input | 8 | Sector number byte |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Completion error flag, valid with done |
| timed_out | output | 1 | Wait limit hit, valid with done |
| dev_addr | output | 5 | Task-file register offset |
| dev_wdata | output | 16 | Register write data |
| dev_wr | output | 1 | Register write strobe |
| dev_rd | output | 1 | Register read strobe; data sampled at the end of the same cycle |
| dev_rdata | input | 16 | Register read data |
| dev_intrq_n | input | 1 | Device interrupt, active low |
| buf_we | output | 1 | Buffer write enable |
| buf_waddr | output | 8 | Buffer write word address |
| buf_wdata | output | 16 | Buffer write word |
| buf_raddr | output | 8 | Buffer read word address |
| buf_rdata | input | 16 | Buffer read word, one cycle after the address |

## Verification
The assertions rely on the following behaviour of the device model:
- It drives dev_rdata combinationally from dev_addr during a dev_rd cycle.
- It never holds dev_intrq_n low before a command has been issued.
- It releases dev_intrq_n when status is read.

The stimulus respects these rules. The bench also raises cmd_valid only on falling edges, and it clears the device model between commands so that no interrupt carries over from one command to the next. The DRQ, ERR and BSY status bits appear only in the scenarios that exercise them.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;
  localparam logic [7:0] OP_IDENT = 8'hEC;
  localparam logic [7:0] OP_RDSEC = 8'h20;
  localparam logic [7:0] OP_WRSEC = 8'h30;

  typedef enum logic [1:0] {K_IDENT, K_READ, K_WRITE} op_kind_t;

  typedef enum logic [3:0] {
    S_IDLE, S_CNT, S_SEC, S_CMD, S_WINT, S_STAT, S_STATW,
    S_RDREQ, S_RDCAP, S_POLL, S_POLLW, S_WFETCH, S_WPUT, S_DONE
  } eng_state_t;
endpackage

// File: rtl/ata_wait_timer.sv
module ata_wait_timer #(
  parameter int LIMIT = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] count;

  always_ff @(posedge clk) begin
    if (rst || !run) count <= '0;
    else if (!expired) count <= count + 1'b1;
  end

  assign expired = (count == CW'(LIMIT));
endmodule

// File: rtl/ata_status_decode.sv
module ata_status_decode (
  input  logic [7:0] status,
  output logic       drq_ready,
  output logic       fault
);
  localparam int B_ERR = 0;
  localparam int B_DRQ = 3;
  localparam int B_BSY = 7;

  always_comb begin
    drq_ready = status[B_DRQ] & ~status[B_BSY];
    fault     = status[B_ERR] | status[B_BSY];
  end
endmodule

// File: rtl/ata_pio_engine.sv
module ata_pio_engine
  import ata_pio_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int DATA_W      = 16,
  parameter int WORDS       = 256,
  parameter int TIMEOUT_CYC = 4096,
  parameter logic [ADDR_W-1:0] REG_DATA    = ADDR_W'(0),
  parameter logic [ADDR_W-1:0] REG_COUNT   = ADDR_W'(9),
  parameter logic [ADDR_W-1:0] REG_SECTOR  = ADDR_W'(11),
  parameter logic [ADDR_W-1:0] REG_CMDSTAT = ADDR_W'(29),
  localparam int WIDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_code,
  input  logic [7:0]        cmd_sector,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic              timed_out,
  output logic [ADDR_W-1:0] dev_addr,
  output logic [DATA_W-1:0] dev_wdata,
  output logic              dev_wr,
  output logic              dev_rd,
  input  logic [DATA_W-1:0] dev_rdata,
  input  logic              dev_intrq_n,
  output logic              buf_we,
  output logic [WIDX_W-1:0] buf_waddr,
  output logic [DATA_W-1:0] buf_wdata,
  output logic [WIDX_W-1:0] buf_raddr,
  input  logic [DATA_W-1:0] buf_rdata
);
  localparam logic [WIDX_W-1:0] LAST = WIDX_W'(WORDS - 1);

  eng_state_t        state;
  op_kind_t          kind;
  logic [7:0]        code_q;
  logic [7:0]        sec_q;
  logic [WIDX_W-1:0] widx;
  logic              waiting;
  logic              expired;
  logic              st_drq;
  logic              st_fault;

  assign waiting   = (state == S_WINT) || (state == S_POLL) || (state == S_POLLW);
  assign buf_raddr = widx;

  ata_wait_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .run     (waiting),
    .expired (expired)
  );

  ata_status_decode u_stat (
    .status    (dev_rdata[7:0]),
    .drq_ready (st_drq),
    .fault     (st_fault)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      kind      <= K_IDENT;
      code_q    <= '0;
      sec_q     <= '0;
      widx      <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      error     <= 1'b0;
      timed_out <= 1'b0;
      dev_addr  <= '0;
      dev_wdata <= '0;
      dev_wr    <= 1'b0;
      dev_rd    <= 1'b0;
      buf_we    <= 1'b0;
      buf_waddr <= '0;
      buf_wdata <= '0;
    end else begin
      dev_wr <= 1'b0;
      dev_rd <= 1'b0;
      buf_we <= 1'b0;
      done   <= 1'b0;
      case (state)
        S_IDLE: begin
          if (cmd_valid) begin
            busy      <= 1'b1;
            error     <= 1'b0;
            timed_out <= 1'b0;
            code_q    <= cmd_code;
            sec_q     <= cmd_sector;
            widx      <= '0;
            case (cmd_code)
              OP_IDENT: begin kind <= K_IDENT; state <= S_CMD; end
              OP_RDSEC: begin kind <= K_READ;  state <= S_CNT; end
              OP_WRSEC: begin kind <= K_WRITE; state <= S_CNT; end
              default:  begin error <= 1'b1;   state <= S_DONE; end
            endcase
          end
        end
        S_CNT: begin
          dev_addr  <= REG_COUNT;
          dev_wdata <= DATA_W'(1);
          dev_wr    <= 1'b1;
          state     <= S_SEC;
        end
        S_SEC: begin
          dev_addr  <= REG_SECTOR;
          dev_wdata <= DATA_W'(sec_q);
          dev_wr    <= 1'b1;
          state     <= S_CMD;
        end
        S_CMD: begin
          dev_addr  <= REG_CMDSTAT;
          dev_wdata <= DATA_W'(code_q);
          dev_wr    <= 1'b1;
          state     <= (kind == K_WRITE) ? S_POLL : S_WINT;
        end
        S_WINT: begin
          if (!dev_intrq_n) state <= S_STAT;
          else if (expired) begin
            error     <= 1'b1;
            timed_out <= 1'b1;
            state     <= S_DONE;
          end
        end
        S_STAT: begin
          dev_addr <= REG_CMDSTAT;
          dev_rd   <= 1'b1;
          state    <= S_STATW;
        end
        S_STATW: begin
          if (st_fault) error <= 1'b1;
          state <= (kind == K_WRITE) ? S_DONE : S_RDREQ;
        end
        S_RDREQ: begin
          dev_addr <= REG_DATA;
          dev_rd   <= 1'b1;
          state    <= S_RDCAP;
        end
        S_RDCAP: begin
          buf_we    <= 1'b1;
          buf_waddr <= widx;
          buf_wdata <= dev_rdata;
          widx      <= widx + 1'b1;
          state     <= (widx == LAST) ? S_DONE : S_RDREQ;
        end
        S_POLL: begin
          dev_addr <= REG_CMDSTAT;
          dev_rd   <= 1'b1;
          state    <= S_POLLW;
        end
        S_POLLW: begin
          if (st_drq) state <= S_WFETCH;
          else if (expired) begin
            error     <= 1'b1;
            timed_out <= 1'b1;
            state     <= S_DONE;
          end else state <= S_POLL;
        end
        S_WFETCH: state <= S_WPUT;
        S_WPUT: begin
          dev_addr  <= REG_DATA;
          dev_wdata <= buf_rdata;
          dev_wr    <= 1'b1;
          widx      <= widx + 1'b1;
          state     <= (widx == LAST) ? S_WINT : S_WFETCH;
        end
        S_DONE: begin
          done  <= 1'b1;
          busy  <= 1'b0;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ata_pio_checker.sv
module ata_pio_checker #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] REG_DATA    = ADDR_W'(0),
  parameter logic [ADDR_W-1:0] REG_CMDSTAT = ADDR_W'(29)
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic              busy,
  input logic              done,
  input logic              error,
  input logic              timed_out,
  input logic [ADDR_W-1:0] dev_addr,
  input logic              dev_wr,
  input logic              dev_rd,
  input logic [DATA_W-1:0] dev_rdata,
  input logic              dev_intrq_n,
  input logic              buf_we
);
  logic irq_seen;
  logic drq_seen;

  always_ff @(posedge clk) begin
    if (rst || (cmd_valid && !busy)) begin
      irq_seen <= 1'b0;
      drq_seen <= 1'b0;
    end else begin
      if (busy && !dev_intrq_n) irq_seen <= 1'b1;
      if (dev_rd && dev_addr == REG_CMDSTAT && dev_rdata[3] && !dev_rdata[7]) drq_seen <= 1'b1;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!busy && !done && !dev_wr && !dev_rd && !buf_we)); // R1

  AST_IRQ_BEFORE_DATA_RD: assert property (@(posedge clk) disable iff (rst)
    (dev_rd && dev_addr == REG_DATA) |-> irq_seen); // R3

  AST_DRQ_BEFORE_DATA_WR: assert property (@(posedge clk) disable iff (rst)
    (dev_wr && dev_addr == REG_DATA) |-> drq_seen); // R5

  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (rst)
    !(dev_wr && dev_rd)); // R6

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7

  AST_TIMEOUT_IS_ERROR: assert property (@(posedge clk) disable iff (rst)
    (done && timed_out) |-> error); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!dev_wr && !dev_rd && !buf_we)); // R10

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
    busy |=> (busy || done)); // R11
endmodule

bind ata_pio_engine ata_pio_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_DATA(REG_DATA), .REG_CMDSTAT(REG_CMDSTAT)
) u_chk (.*);

// File: tb/sim_ata_pio_engine.sv
module sim_ata_pio_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [7:0]  cmd_code = '0;
  logic [7:0]  cmd_sector = '0;
  logic        busy, done, error, timed_out;
  logic [4:0]  dev_addr;
  logic [15:0] dev_wdata, dev_rdata;
  logic        dev_wr, dev_rd;
  logic        dev_intrq_n;
  logic        buf_we;
  logic [7:0]  buf_waddr, buf_raddr;
  logic [15:0] buf_wdata, buf_rdata;

  always #10 clk = ~clk;

  ata_pio_engine #(.TIMEOUT_CYC(300)) u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_sector(cmd_sector), .busy(busy), .done(done), .error(error),
    .timed_out(timed_out), .dev_addr(dev_addr), .dev_wdata(dev_wdata),
    .dev_wr(dev_wr), .dev_rd(dev_rd), .dev_rdata(dev_rdata),
    .dev_intrq_n(dev_intrq_n), .buf_we(buf_we), .buf_waddr(buf_waddr),
    .buf_wdata(buf_wdata), .buf_raddr(buf_raddr), .buf_rdata(buf_rdata)
  );

  int checks = 0;
  int failures = 0;

  function automatic logic [15:0] rx_pat(input int k);
    return 16'h3C00 ^ 16'(k * 257);
  endfunction
  function automatic logic [15:0] tx_pat(input int k);
    return 16'h9100 + 16'(k * 3);
  endfunction

  // device model knobs, driven only by the initial block
  int irq_delay = 20;
  bit irq_never = 0, err_inj = 0, bsy_inj = 0, drq_never = 0;
  int drq_delay = 0;
  bit dev_clr = 0;

  // device model state
  logic [15:0] tx_mem [256];
  logic [15:0] rx_mem [256];
  logic        intrq_q = 1'b1;
  int irq_cnt = 0, reg_writes = 0, cmd_writes = 0, data_rd = 0, data_wr = 0;
  int wr_mism = 0, polls = 0, stat_at_first = -1, rd_before_irq = 0;
  int wr_before_drq = 0, stat_after_wr = 0;
  bit irq_fell = 0, drq_shown = 0, wr_mode = 0;
  logic [4:0]  log_a [4];
  logic [15:0] log_d [4];
  logic [7:0]  status;
  logic        drq_now;

  assign dev_intrq_n = intrq_q;
  assign drq_now = wr_mode && !drq_never && (polls >= drq_delay) && (data_wr < 256);
  assign status  = {bsy_inj, 1'b1, 2'b00, drq_now, 2'b00, err_inj};
  assign dev_rdata = (dev_addr == 5'h1D) ? {8'h00, status} :
                     (dev_addr == 5'h00) ? rx_pat(data_rd) : 16'h0000;

  always @(posedge clk) begin
    buf_rdata <= tx_mem[buf_raddr];
    if (buf_we) rx_mem[buf_waddr] <= buf_wdata;
    if (dev_clr) begin
      intrq_q <= 1'b1; irq_cnt <= 0; reg_writes <= 0; cmd_writes <= 0;
      data_rd <= 0; data_wr <= 0; wr_mism <= 0; polls <= 0; stat_at_first <= -1;
      rd_before_irq <= 0; wr_before_drq <= 0; stat_after_wr <= 0;
      irq_fell <= 0; drq_shown <= 0; wr_mode <= 0;
      for (int i = 0; i < 4; i++) begin log_a[i] <= '0; log_d[i] <= '0; end
    end else begin
      if (!intrq_q) irq_fell <= 1;
      if (irq_cnt > 0) begin
        irq_cnt <= irq_cnt - 1;
        if (irq_cnt == 1) intrq_q <= 1'b0;
      end
      if (dev_wr) begin
        if (dev_addr == 5'h00) begin
          if (tx_mem[data_wr[7:0]] != dev_wdata) wr_mism <= wr_mism + 1;
          if (!drq_shown) wr_before_drq <= wr_before_drq + 1;
          data_wr <= data_wr + 1;
          if (data_wr == 255 && !irq_never) irq_cnt <= irq_delay;
        end else begin
          if (reg_writes < 4) begin log_a[reg_writes] <= dev_addr; log_d[reg_writes] <= dev_wdata; end
          reg_writes <= reg_writes + 1;
          if (dev_addr == 5'h1D) begin
            cmd_writes <= cmd_writes + 1;
            if (dev_wdata[7:0] == 8'h30) wr_mode <= 1;
            else if (!irq_never) irq_cnt <= irq_delay;
          end
        end
      end
      if (dev_rd) begin
        if (dev_addr == 5'h1D) begin
          polls <= polls + 1;
          intrq_q <= 1'b1;
          if (status[3]) drq_shown <= 1;
          if (data_wr == 256) stat_after_wr <= stat_after_wr + 1;
        end else if (dev_addr == 5'h00) begin
          if (data_rd == 0) stat_at_first <= polls;
          if (!irq_fell) rd_before_irq <= rd_before_irq + 1;
          data_rd <= data_rd + 1;
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  bit got_done, got_err, got_tmo;

  task automatic run_cmd(input logic [7:0] code, input logic [7:0] sec);
    dev_clr = 1; @(negedge clk); dev_clr = 0;
    cmd_code = code; cmd_sector = sec; cmd_valid = 1;
    @(negedge clk); cmd_valid = 0;
    got_done = 0;
    for (int i = 0; i < 5000 && !got_done; i++) begin
      if (done) begin got_done = 1; got_err = error; got_tmo = timed_out; end
      else @(negedge clk);
    end
    check(got_done, "R7", "done seen", got_done, 1);
    @(negedge clk);
    check(done == 1'b0, "R7", "done single pulse", done, 0);
  endtask

  task automatic rx_compare(input string req);
    int bad = 0;
    for (int k = 0; k < 256; k++) if (rx_mem[k] !== rx_pat(k)) bad++;
    check(bad == 0, req, "buffer words mismatched", bad, 0);
  endtask

  task automatic t_reset;
    check(!busy && !done && !dev_wr && !dev_rd && !buf_we, "R1", "reset outputs",
          {busy, done, dev_wr, dev_rd, buf_we}, 0);
  endtask

  task automatic t_identify;
    for (int k = 0; k < 256; k++) rx_mem[k] = 16'hDEAD;
    run_cmd(8'hEC, 8'h00);
    check(reg_writes == 1 && log_a[0] == 5'h1D && log_d[0] == 16'h00EC, "R2",
          "identify register writes", reg_writes, 1);
    check(rd_before_irq == 0, "R3", "data read before interrupt", rd_before_irq, 0);
    check(stat_at_first >= 1, "R3", "status read before data", stat_at_first, 1);
    check(data_rd == 256, "R4", "identify data reads", data_rd, 256);
    rx_compare("R4");
    check(!got_err && !got_tmo, "R8", "identify clean error", got_err, 0);
  endtask

  task automatic t_read;
    run_cmd(8'h20, 8'h0A);
    check(reg_writes == 3, "R2", "read register write count", reg_writes, 3);
    check(log_a[0] == 5'h09 && log_d[0] == 16'h0001, "R2", "count reg first", log_a[0], 5'h09);
    check(log_a[1] == 5'h0B && log_d[1] == 16'h000A, "R2", "sector reg second", log_d[1], 16'h000A);
    check(log_a[2] == 5'h1D && log_d[2] == 16'h0020, "R2", "command third", log_d[2], 16'h0020);
    check(data_rd == 256, "R4", "read data count", data_rd, 256);
    rx_compare("R4");
    check(!got_err, "R8", "read clean error", got_err, 0);
  endtask

  task automatic t_write;
    drq_delay = 4;
    run_cmd(8'h30, 8'h21);
    check(log_d[2] == 16'h0030 && reg_writes == 3, "R2", "write command sequence", log_d[2], 16'h0030);
    check(wr_before_drq == 0, "R5", "data written before DRQ", wr_before_drq, 0);
    check(polls >= 5, "R5", "status polls before DRQ", polls, 5);
    check(data_wr == 256, "R6", "write data count", data_wr, 256);
    check(wr_mism == 0, "R6", "write word mismatches", wr_mism, 0);
    check(stat_after_wr == 1, "R7", "final status reads", stat_after_wr, 1);
    check(!got_err && !got_tmo, "R8", "write clean error", got_err, 0);
    drq_delay = 0;
  endtask

  task automatic t_errors;
    err_inj = 1;
    run_cmd(8'h20, 8'h03);
    check(got_err && !got_tmo, "R8", "ERR bit flagged", got_err, 1);
    err_inj = 0; bsy_inj = 1;
    run_cmd(8'hEC, 8'h00);
    check(got_err && !got_tmo, "R8", "BSY bit flagged", got_err, 1);
    bsy_inj = 0;
  endtask

  task automatic t_timeouts;
    irq_never = 1;
    run_cmd(8'h20, 8'h05);
    check(got_err && got_tmo, "R9", "interrupt timeout flags", {got_err, got_tmo}, 3);
    check(data_rd == 0, "R9", "no reads after irq timeout", data_rd, 0);
    irq_never = 0; drq_never = 1;
    run_cmd(8'h30, 8'h05);
    check(got_err && got_tmo, "R9", "DRQ timeout flags", {got_err, got_tmo}, 3);
    check(data_wr == 0, "R9", "no writes after DRQ timeout", data_wr, 0);
    drq_never = 0;
  endtask

  task automatic t_bad_code;
    run_cmd(8'h55, 8'h01);
    check(got_err && !got_tmo, "R10", "bad code error", got_err, 1);
    check(reg_writes == 0 && data_rd == 0 && polls == 0, "R10", "bus untouched",
          reg_writes + data_rd + polls, 0);
  endtask

  task automatic t_ignore_busy;
    irq_delay = 100;
    dev_clr = 1; @(negedge clk); dev_clr = 0;
    cmd_code = 8'h20; cmd_sector = 8'h0A; cmd_valid = 1;
    @(negedge clk); cmd_valid = 0;
    repeat (10) @(negedge clk);
    cmd_code = 8'h30; cmd_sector = 8'h77; cmd_valid = 1;
    @(negedge clk); cmd_valid = 0;
    got_done = 0;
    for (int i = 0; i < 5000 && !got_done; i++) begin
      if (done) begin got_done = 1; got_err = error; end
      else @(negedge clk);
    end
    check(got_done && cmd_writes == 1, "R11", "second request ignored", cmd_writes, 1);
    check(log_d[1] == 16'h000A && data_wr == 0 && data_rd == 256, "R11",
          "transfer unchanged", data_rd, 256);
    irq_delay = 20;
    @(negedge clk);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      failures++;
      $display("FAIL watchdog: actual=%0d expected=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 256; k++) tx_mem[k] = tx_pat(k);
    repeat (3) @(negedge clk);
    t_reset();
    rst = 0;
    @(negedge clk);
    t_reset();
    t_identify();
    t_read();
    t_write();
    t_errors();
    t_timeouts();
    t_bad_code();
    t_ignore_busy();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule